// File: doc/BRIEF.md
# Divider-Paced Logic Sampling Engine

This block captures an eight-wide bus of digital probe lines at a programmable rate and returns the captured bytes to a host in bursts that the host requests. Each probe line passes through a two-flop synchroniser. A pacing counter then fires a sample strobe once every `1 + divider` clock cycles. At each strobe the whole probe bus is taken as one byte. The block does no triggering and no analysis of the data; it only delivers the bytes.

The rate is set with a two-byte command on a byte stream. The first byte is an opcode and the second byte is the divider. A read request carries a sample count. The block captures exactly that many samples and offers them on a valid/ready output stream. Back-pressure on the output goes into a small FIFO. If the FIFO is full when a strobe fires and nothing leaves the FIFO in that cycle, the sample is dropped and a sticky overflow flag is set. The capture rate itself is never slowed. A one-cycle done pulse ends each burst.

The command stream has no ready signal: every byte with `cmd_valid` high is consumed. The request port accepts a request only while `req_ready` is high, which is whenever no burst is in progress. On the output, `smp_valid` stays high and `smp_data` stays unchanged until the host raises `smp_ready`.

Top module: `pbs_sampler`

## Requirements
- R1: A command byte of 0x01 or 0xD5, followed by any byte on the next valid command transfer, loads that second byte as the pending divider.
- R2: A first command byte that is neither 0x01 nor 0xD5 is discarded. The parser keeps waiting for an opcode, so the byte after it is also treated as an opcode candidate and not as a divider.
- R3: During a burst, successive sample strobes are exactly `1 + d` clock cycles apart, where `d` is the active divider and a divider of 0 is treated as 1. Consecutive sample bytes therefore reflect probe states `1 + d` cycles apart.
- R4: Bit i of a sample byte is the synchronised state of `probe_i[i]`. Bit 7 carries probe 1 and bit 0 carries probe 8.
- R5: An accepted request with count n returns exactly min(n, 4096) samples. A request with count 0 is ignored and produces no bytes and no done pulse.
- R6: `req_ready` is high exactly when no burst is in progress. A request presented while a burst runs has no effect until `req_ready` is high again. A request that is held high is accepted in the cycle in which the previous burst's done pulse is asserted.
- R7: The active divider is copied from the pending divider when a request is accepted. A command that completes during a burst changes the rate only from the next request on.
- R8: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` holds its value on the next cycle.
- R9: Under back-pressure the FIFO keeps the oldest samples. A strobe that finds the FIFO full, in a cycle with no output transfer, drops its sample and sets `overflow`. `overflow` then stays high until reset.
- R10: `burst_done` is a one-cycle pulse in the cycle after the burst's last sample is either transferred on the output or dropped. `req_ready` is high in that same cycle.
- R11: After reset, `smp_valid`, `burst_done` and `overflow` are low, `req_ready` is high, and the pending divider is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe_i | input | 8 | Asynchronous probe lines; bit 7 is probe 1 |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_data | input | 8 | Command byte (opcode or divider) |
| req_valid | input | 1 | A read request is present |
| req_count | input | 16 | Requested number of samples |
| req_ready | output | 1 | Idle; a request is accepted this cycle |
| smp_valid | output | 1 | A sample byte is offered |
| smp_data | output | 8 | Sample byte |
| smp_ready | input | 1 | Host takes the offered byte |
| burst_done | output | 1 | One-cycle pulse when a burst ends |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
Two events can fall in the same cycle. The first is the done pulse of one burst together with the acceptance of the next request. The bench provokes it by holding `req_valid` high across a whole burst. It then expects exactly twice the requested byte count and two done pulses, with `req_ready` reading low while the first burst runs. The second is a rate command that completes while a burst runs. The bench judges it by the spacing of the handshake cycles and by the arithmetic difference of consecutive bytes taken from a free-running counter on the probes. The old spacing must hold to the end of the running burst, and the new spacing must apply to the burst after it.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] OPC_RATE     = 8'h01;
  localparam logic [CMD_W-1:0] OPC_RATE_ALT = 8'hD5;

  typedef enum logic {
    ST_OPCODE  = 1'b0,
    ST_DIVIDER = 1'b1
  } parse_st_e;
endpackage

// File: rtl/pbs_sync.sv
`timescale 1ns/1ps
module pbs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '0;
          else        r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '0;
          else        r <= g_stage[g-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/pbs_cmd_parse.sv
`timescale 1ns/1ps
module pbs_cmd_parse
  import pbs_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  output logic [DIV_W-1:0] pend_div
);
  parse_st_e state;
  logic      is_opc;

  assign is_opc = (cmd_byte == OPC_RATE) || (cmd_byte == OPC_RATE_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OPCODE;
      pend_div <= DIV_W'(RST_DIV);
    end else if (cmd_valid) begin
      case (state)
        ST_OPCODE: begin
          if (is_opc) state <= ST_DIVIDER;
        end
        default: begin
          pend_div <= cmd_byte[DIV_W-1:0];
          state    <= ST_OPCODE;
        end
      endcase
    end
  end

  AST_DIV_THEN_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIVIDER && cmd_valid) |=> (state == ST_OPCODE)); // R1
  AST_BAD_OPC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPCODE && cmd_valid && !is_opc) |=> (state == ST_OPCODE && $stable(pend_div))); // R2
endmodule

// File: rtl/pbs_pacer.sv
`timescale 1ns/1ps
module pbs_pacer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_div,
  input  logic             en,
  output logic             strobe
);
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] cnt;

  assign strobe = en && (cnt == act_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= DIV_W'(1);
      cnt     <= '0;
    end else if (load) begin
      act_div <= (load_div == '0) ? DIV_W'(1) : load_div;
      cnt     <= '0;
    end else if (en) begin
      cnt <= strobe ? '0 : cnt + 1'b1;
    end
  end

  AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R3
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> $stable(act_div)); // R7
endmodule

// File: rtl/pbs_fifo.sv
`timescale 1ns/1ps
module pbs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && !do_push;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == CW'(DEPTH))); // R9
endmodule

// File: rtl/pbs_sampler.sv
`timescale 1ns/1ps
module pbs_sampler
  import pbs_pkg::*;
#(
  parameter int PROBES     = 8,
  parameter int DIV_W      = 8,
  parameter int RST_DIV    = 1,
  parameter int MAX_BURST  = 4096,
  parameter int REQ_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROBES-1:0] probe_i,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              req_valid,
  input  logic [REQ_W-1:0]  req_count,
  output logic              req_ready,
  output logic              smp_valid,
  output logic [PROBES-1:0] smp_data,
  input  logic              smp_ready,
  output logic              burst_done,
  output logic              overflow
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);
  localparam logic [REQ_W-1:0] MAX_REQ = REQ_W'(MAX_BURST);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BURST);

  logic [PROBES-1:0] probe_s;
  logic [DIV_W-1:0]  pend_div;
  logic              busy, accept, en, strobe;
  logic              pop, drop, resolve, fifo_empty;
  logic [CNT_W-1:0]  cap_left, out_left, eff_count;
  logic              done_q, ovf_q;

  pbs_sync #(.W(PROBES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(probe_i), .q(probe_s)
  );

  pbs_cmd_parse #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_parse (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_data),
    .pend_div(pend_div)
  );

  pbs_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_div(pend_div),
    .en(en), .strobe(strobe)
  );

  pbs_fifo #(.W(PROBES), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(strobe), .din(probe_s), .pop(pop),
    .dout(smp_data), .empty(fifo_empty), .drop(drop)
  );

  assign req_ready  = !busy;
  assign accept     = req_valid && !busy && (req_count != '0);
  assign eff_count  = (req_count > MAX_REQ) ? MAX_CNT : req_count[CNT_W-1:0];
  assign en         = busy && (cap_left != '0);
  assign smp_valid  = !fifo_empty;
  assign pop        = smp_valid && smp_ready;
  assign resolve    = pop || drop;
  assign burst_done = done_q;
  assign overflow   = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cap_left <= '0;
      out_left <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (drop) ovf_q <= 1'b1;
      if (accept) begin
        busy     <= 1'b1;
        cap_left <= eff_count;
        out_left <= eff_count;
      end else begin
        if (strobe) cap_left <= cap_left - 1'b1;
        if (resolve && busy) begin
          out_left <= out_left - 1'b1;
          if (out_left == CNT_W'(1)) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> req_ready); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !smp_valid); // R6
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_left <= MAX_CNT) && (cap_left <= out_left)); // R5
endmodule

// File: tb/pbs_sampler_tb.sv
`timescale 1ns/1ps
module pbs_sampler_tb;
  localparam int MAXH = 4200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  probe_i;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_count = '0;
  logic        req_ready, smp_valid, smp_ready, burst_done, overflow;
  logic [7:0]  smp_data;

  logic        free_run = 1'b1;
  logic [7:0]  fixed_val = '0;
  logic [7:0]  pcnt = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int hs_n = 0;
  int done_n = 0;
  int last_hs = 0;
  int done_gap = 0;
  logic done_rdy = 1'b0;
  int hs_t [MAXH];
  int hs_d [MAXH];

  always #5 clk = ~clk;

  assign probe_i = free_run ? pcnt : fixed_val;

  always @(posedge clk) begin
    cyc++;
    pcnt <= pcnt + 8'd1;
  end

  pbs_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .probe_i(probe_i),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .req_valid(req_valid), .req_count(req_count), .req_ready(req_ready),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .burst_done(burst_done), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid && smp_ready) begin
        if (hs_n < MAXH) begin
          hs_t[hs_n] = cyc;
          hs_d[hs_n] = int'(smp_data);
        end
        hs_n++;
        last_hs = cyc;
      end
      if (burst_done) begin
        done_n++;
        done_gap = cyc - last_hs;
        done_rdy = req_ready;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_data = b;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic set_div(input logic [7:0] opc, input logic [7:0] d);
    send_cmd(opc);
    send_cmd(d);
  endtask

  task automatic clear_log();
    hs_n = 0; done_n = 0;
  endtask

  task automatic start_req(input int n);
    @(posedge clk); #1;
    req_valid = 1'b1; req_count = 16'(n);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    int k;
    k = 0;
    while (done_n < target && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(done_n >= target, req, "done pulse count", done_n, target);
  endtask

  task automatic check_pacing(input int d, input string req);
    int bad_gap, bad_dat, ag, eg, ad, ed, n;
    bad_gap = 0; bad_dat = 0; ag = 0; ad = 0;
    eg = d + 1;
    ed = (d + 1) & 255;
    n = (hs_n < MAXH) ? hs_n : MAXH;
    for (int i = 1; i < n; i++) begin
      if (hs_t[i] - hs_t[i-1] != eg) begin
        if (bad_gap == 0) ag = hs_t[i] - hs_t[i-1];
        bad_gap++;
      end
      if (((hs_d[i] - hs_d[i-1]) & 255) != ed) begin
        if (bad_dat == 0) ad = (hs_d[i] - hs_d[i-1]) & 255;
        bad_dat++;
      end
    end
    check(bad_gap == 0, req, "strobe spacing", ag, eg);
    check(bad_dat == 0, req, "sample byte step", ad, ed);
  endtask

  task automatic burst(input int n, input int exp_n, input int d, input string req);
    clear_log();
    start_req(n);
    wait_done(1, req);
    check(hs_n == exp_n, req, "byte count", hs_n, exp_n);
    check_pacing(d, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d0;
    smp_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!smp_valid, "R11", "smp_valid after reset", smp_valid, 0);
    check(!burst_done, "R11", "burst_done after reset", burst_done, 0);
    check(!overflow, "R11", "overflow after reset", overflow, 0);
    check(req_ready, "R11", "req_ready after reset", req_ready, 1);

    // R11 default divider of 1, R10 done timing
    burst(5, 5, 1, "R11");
    check(done_gap == 1, "R10", "done delay after last byte", done_gap, 1);
    check(done_rdy, "R10", "req_ready with done", done_rdy, 1);

    // R1 / R3 sweep of dividers, alternating both opcodes, divider 0 as 1
    for (int d = 0; d < 32; d++) begin
      set_div((d % 2) ? 8'hD5 : 8'h01, 8'(d));
      burst(3, 3, (d == 0) ? 1 : d, (d % 2) ? "R1" : "R3");
    end
    set_div(8'hD5, 8'd255);
    burst(3, 3, 255, "R3");

    // R2 invalid opcode discarded, following byte not a divider
    set_div(8'h01, 8'd6);
    send_cmd(8'h02);
    send_cmd(8'h09);
    burst(3, 3, 6, "R2");
    send_cmd(8'h33);
    set_div(8'h01, 8'd4);
    burst(3, 3, 4, "R2");

    // R4 bit mapping of probes into the byte
    free_run = 1'b0;
    foreach (hs_d[i]) if (i < 1) hs_d[i] = 0;
    fixed_val = 8'h80; repeat (4) @(posedge clk);
    clear_log(); start_req(2); wait_done(1, "R4");
    check(hs_d[0] == 8'h80, "R4", "probe 1 at bit 7", hs_d[0], 8'h80);
    fixed_val = 8'h01; repeat (4) @(posedge clk);
    clear_log(); start_req(2); wait_done(1, "R4");
    check(hs_d[0] == 8'h01, "R4", "probe 8 at bit 0", hs_d[0], 8'h01);
    fixed_val = 8'hA5; repeat (4) @(posedge clk);
    clear_log(); start_req(2); wait_done(1, "R4");
    check(hs_d[1] == 8'hA5, "R4", "mixed pattern", hs_d[1], 8'hA5);
    free_run = 1'b1;

    // R5 clamp and zero-count request
    set_div(8'h01, 8'd1);
    burst(5000, 4096, 1, "R5");
    clear_log();
    start_req(0);
    repeat (30) @(negedge clk);
    check(hs_n == 0, "R5", "bytes for zero request", hs_n, 0);
    check(done_n == 0, "R5", "done for zero request", done_n, 0);

    // R7 command during a burst applies only to the next one
    set_div(8'h01, 8'd3);
    clear_log();
    start_req(8);
    set_div(8'h01, 8'd9);
    wait_done(1, "R7");
    check(hs_n == 8, "R7", "byte count", hs_n, 8);
    check_pacing(3, "R7");
    burst(4, 4, 9, "R7");

    // R6 held request: ignored while busy, accepted in the done cycle
    set_div(8'h01, 8'd2);
    clear_log();
    @(posedge clk); #1;
    req_valid = 1'b1; req_count = 16'd5;
    @(posedge clk);
    @(negedge clk);
    check(!req_ready, "R6", "req_ready during burst", req_ready, 0);
    wait_done(1, "R6");
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_done(2, "R6");
    repeat (20) @(negedge clk);
    check(hs_n == 10, "R6", "bytes for two held bursts", hs_n, 10);
    check(done_n == 2, "R6", "done pulses", done_n, 2);

    // R8 / R9 back-pressure, overflow and oldest-kept
    set_div(8'h01, 8'd1);
    check(!overflow, "R9", "overflow before stall", overflow, 0);
    smp_ready = 1'b0;
    clear_log();
    start_req(10);
    repeat (40) @(negedge clk);
    check(overflow, "R9", "overflow after drop", overflow, 1);
    check(smp_valid, "R8", "valid held under stall", smp_valid, 1);
    d0 = int'(smp_data);
    repeat (3) @(negedge clk);
    check(smp_valid && int'(smp_data) == d0, "R8", "data stable under stall",
          int'(smp_data), d0);
    check(!req_ready, "R6", "busy while bytes pending", req_ready, 0);
    @(posedge clk); #1;
    smp_ready = 1'b1;
    wait_done(1, "R10");
    check(hs_n == 4, "R9", "bytes kept in FIFO", hs_n, 4);
    check(((hs_d[1] - hs_d[0]) & 255) == 2, "R9", "oldest samples kept",
          (hs_d[1] - hs_d[0]) & 255, 2);
    check(done_gap == 1, "R10", "done after drain", done_gap, 1);
    repeat (5) @(negedge clk);
    check(overflow, "R9", "overflow sticky", overflow, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule